// File: doc/BRIEF.md
# I2C Register Target

This block is a bus target for a two-wire I2C link. It gives a host access to a small bank of byte-wide registers. It never drives the clock line and never begins a transfer. It only follows what a controller does on SCL and SDA, and it pulls SDA low when it has to acknowledge or send a zero. Both lines are sampled by a system clock that runs many times faster than SCL. Each line passes through a synchronizer before any edge or bus condition is decoded.

The seven-bit bus address has two parts. The upper three bits are a constant 3'b011. The lower four bits are the upper nibble of a control register that sits inside the same bank, so the host can move the device to a new address by writing that register.

A write transfer works as follows:
- The first data byte sets an internal pointer.
- Each later byte lands in the register at the pointer, and the pointer then advances.

A read transfer streams bytes out from the pointer. A START that arrives without an earlier STOP closes the packet in progress and opens a fresh one.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is held and after it is released, `sda_drive_low` is 0. The control register (index 0) resets to 8'h80, so the bus address out of reset is 7'h38.
- R2: The first byte after a START is seven address bits, MSB first, then a direction bit (0 = controller writes, 1 = controller reads). When the address bits equal {3'b011, control[7:4]}, the block pulls SDA low during the ninth clock (ACK).
- R3: When the address does not match, SDA stays released in the ninth clock (NACK). Every later byte is then ignored and left unacknowledged, and no register changes, until the next START or STOP.
- R4: In a write transfer, the first data byte loads the pointer (its low log2(NUM_REGS) bits). Each later byte is stored at the pointer, and the pointer then increases by one. Every data byte is ACKed.
- R5: In a read transfer, the byte at the pointer is shifted out MSB first. After each byte, the pointer advances only if the controller answers ACK (SDA low) in the ninth clock, and the next byte then follows.
- R6: A controller NACK ends the read. SDA is released and the pointer keeps the index of the last byte sent, so a new read with no pointer byte starts from that same byte.
- R7: A repeated START with no STOP before it ends the current packet and starts address decoding again. In a write, the first byte after it is treated as a pointer again.
- R8: Writing the control register takes effect at once. After the write, the old address is NACKed and the address built from the new nibble is ACKed.
- R9: The pointer wraps from NUM_REGS-1 to 0, on writes and on reads.
- R10: The block changes `sda_drive_low` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | SCL line as seen at the pad |
| sda_in | input | 1 | SDA line as seen at the pad |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases the line |

## Verification
Several kinds of traffic run against one modelled open-drain bus:
- Multi-byte writes followed by reads. These show whether the pointer byte and the data bytes are told apart, and whether the pointer advances.
- Reads that end on a controller NACK. These show whether the pointer stops on the last byte sent.
- Transfers to a wrong address that carry data bytes. These show the NACK and the ignored bytes, and a read-back proves that no register changed.
- A write that crosses the top index into the control register. It checks the pointer wrap and the run-time address change together.
- A repeated START placed in the middle of write traffic. It shows that the next byte becomes a pointer again.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
// Shared types for the I2C register target.
// Holds the protocol state encoding and the fixed part of the bus address.
package i2c_tgt_pkg;

    localparam logic [2:0] DEV_PREFIX = 3'b011;

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for START
        ST_ADDR,      // shifting in address + direction
        ST_ACK_ADDR,  // driving ACK for our address
        ST_WDATA,     // shifting in a written byte
        ST_ACK_W,     // driving ACK for a written byte
        ST_RDATA,     // shifting out a read byte
        ST_RACK,      // sampling the controller's ACK/NACK
        ST_IGNORE     // not addressed or read finished; wait for START/STOP
    } i2c_state_e;

endpackage

// File: rtl/i2c_pin_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for one bus line.
// Assumes the line idles high, so every stage resets to 1. STAGES must be 2 or more.
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw pad value through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/i2c_bus_events.sv
`timescale 1ns/1ps
// Decodes SCL edges and START/STOP conditions from synchronized lines.
// Assumes both inputs come from synchronizers of equal latency.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d, sda_d;

    // Keep the previous sample of each line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  = !scl_d && scl_s;
    assign scl_fall  = scl_d && !scl_s;
    assign start_det = scl_d && scl_s && sda_d && !sda_s;
    assign stop_det  = scl_d && scl_s && !sda_d && sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
`timescale 1ns/1ps
// Byte register bank with one write port and one combinational read port.
// Register CTRL_IDX resets to CTRL_RST and exports its upper nibble as the
// variable part of the bus address. NUM_REGS must be a power of two.
module i2c_reg_bank #(
    parameter int         NUM_REGS = 16,
    parameter int         CTRL_IDX = 0,
    parameter logic [7:0] CTRL_RST = 8'h80,
    localparam int        PTR_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [7:0]       rd_data,
    output logic [3:0]       dev_nib
);
    logic [7:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] RST_VAL = (g == CTRL_IDX) ? CTRL_RST : 8'h00;
        // Hold one register; load it when the write port selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                  regs[g] <= RST_VAL;
            else if (wr_en && wr_addr == PTR_W'(g))      regs[g] <= wr_data;
        end
    end

    assign rd_data = regs[rd_addr];
    assign dev_nib = regs[CTRL_IDX][7:4];
endmodule

// File: rtl/i2c_target_fsm.sv
`timescale 1ns/1ps
// Byte-level protocol engine of the I2C target.
// Samples SDA on SCL rise, changes its SDA drive only on SCL fall, and treats
// START/STOP as overriding every state. Assumes no clock stretching is needed.
module i2c_target_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_s,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [3:0]       dev_nib,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_addr,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             sda_oe,
    output i2c_state_e       state,
    output logic [PTR_W-1:0] ptr
);
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] txreg;
    logic       is_read;
    logic       first_byte;
    logic       mack;

    // Next byte for a read continues at ptr+1 while the controller's ACK is pending.
    assign rd_addr = (state == ST_RACK) ? PTR_W'(ptr + 1'b1) : ptr;

    // Protocol sequencing, pointer update and SDA drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            txreg      <= '0;
            is_read    <= 1'b0;
            first_byte <= 1'b0;
            mack       <= 1'b0;
            ptr        <= '0;
            sda_oe     <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == {DEV_PREFIX, dev_nib}) begin
                                    is_read <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    state   <= ST_ACK_ADDR;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else begin
                                if (first_byte) begin
                                    ptr        <= shreg[PTR_W-1:0];
                                    first_byte <= 1'b0;
                                end else begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr + 1'b1;
                                end
                                sda_oe <= 1'b1;
                                state  <= ST_ACK_W;
                            end
                        end
                    end
                    ST_ACK_ADDR: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                txreg  <= rd_data;
                                sda_oe <= !rd_data[7];
                                state  <= ST_RDATA;
                            end else begin
                                sda_oe     <= 1'b0;
                                first_byte <= 1'b1;
                                state      <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK_W: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_RACK;
                            end else begin
                                txreg  <= {txreg[6:0], 1'b0};
                                sda_oe <= !txreg[6];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            mack <= !sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                ptr     <= ptr + 1'b1;
                                txreg   <= rd_data;
                                sda_oe  <= !rd_data[7];
                                bit_cnt <= '0;
                                state   <= ST_RDATA;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
`timescale 1ns/1ps
// I2C target with a byte register bank (top level).
// Assumes clk oversamples SCL well enough that every SCL phase lasts several
// clk cycles beyond the synchronizer latency. SDA is open-drain: the pad
// logic pulls the line low while sda_drive_low is 1.
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter int         NUM_REGS    = 16,
    parameter int         CTRL_IDX    = 0,
    parameter logic [7:0] CTRL_RST    = 8'h80,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_drive_low
);
    localparam int PTR_W = $clog2(NUM_REGS);

    logic             scl_s, sda_s;
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic [PTR_W-1:0] rd_addr, wr_addr, ptr;
    logic [7:0]       rd_data, wr_data;
    logic [3:0]       dev_nib;
    logic             wr_en, sda_oe;
    i2c_state_e       state;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

    i2c_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det));

    i2c_target_fsm #(.PTR_W(PTR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .dev_nib(dev_nib), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sda_oe(sda_oe), .state(state), .ptr(ptr));

    i2c_reg_bank #(.NUM_REGS(NUM_REGS), .CTRL_IDX(CTRL_IDX), .CTRL_RST(CTRL_RST)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dev_nib(dev_nib));

    assign sda_drive_low = sda_oe;
endmodule

// File: rtl/i2c_reg_target_chk.sv
`timescale 1ns/1ps
// Protocol checker bound to the I2C register target.
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_s,
    input logic             sda_oe,
    input i2c_state_e       state,
    input logic             wr_en,
    input logic [PTR_W-1:0] wr_addr,
    input logic [PTR_W-1:0] ptr
);
    // R1
    reset_release_chk: assert property (@(posedge clk) !rst_n |=> !sda_oe);

    // R3
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |-> !sda_oe);

    // R3
    ignore_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |=> (state == ST_IGNORE || state == ST_ADDR || state == ST_IDLE));

    // R4
    wr_ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ptr == PTR_W'(wr_addr + 1'b1));

    // R10
    sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_s));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .state(state),
    .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ptr));

// File: tb/tb_i2c_reg_target.sv
`timescale 1ns/1ps
// Scoreboard bench: bus tasks queue expected bytes/ACKs, a monitor compares.
module tb_i2c_reg_target;
    localparam int Q = 16;  // clk cycles per quarter SCL period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda_low = 1'b0;
    logic dut_low;
    logic sda_line;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [7:0] exp_val[$];
    string      exp_tag[$];
    logic [7:0] act_q[$];

    always #2.5 clk = ~clk;

    assign sda_line = ~(m_sda_low | dut_low);

    i2c_reg_target dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .sda_drive_low(dut_low));

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input logic [7:0] v, input string tag);
        exp_val.push_back(v);
        exp_tag.push_back(tag);
    endtask

    task automatic bus_start();
        m_sda_low = 1'b0; tick(Q);
        m_scl = 1'b1;     tick(Q);
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b0;     tick(Q);
    endtask

    task automatic bus_stop();
        m_sda_low = 1'b1; tick(Q);
        m_scl = 1'b1;     tick(Q);
        m_sda_low = 1'b0; tick(Q);
    endtask

    // Send one byte and record the target's ACK (1) or NACK (0).
    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        expect_item({7'b0, exp_ack}, tag);
        for (int i = 7; i >= 0; i--) begin
            m_sda_low = !b[i]; tick(Q);
            m_scl = 1'b1;      tick(2*Q);
            m_scl = 1'b0;      tick(Q);
        end
        m_sda_low = 1'b0; tick(Q);
        m_scl = 1'b1;     tick(Q);
        act_q.push_back({7'b0, !sda_line});
        tick(Q);
        m_scl = 1'b0;     tick(Q);
    endtask

    // Receive one byte, then answer ACK (mack=1) or NACK.
    task automatic recv_byte(input logic [7:0] expv, input logic mack, input string tag);
        logic [7:0] got;
        expect_item(expv, tag);
        m_sda_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            got[i] = sda_line;
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        act_q.push_back(got);
        m_sda_low = mack; tick(Q);
        m_scl = 1'b1;     tick(2*Q);
        m_scl = 1'b0;     tick(Q);
        m_sda_low = 1'b0;
    endtask

    // Monitor: pop results as they appear and compare them with the expectations.
    initial begin
        forever begin
            @(posedge clk);
            while (act_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_val.pop_front();
                t = exp_tag.pop_front();
                checks++;
                if (a !== e) begin
                    failures++;
                    $display("FAIL %s actual=%02h expected=%02h", t, a, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(5);
        checks++;
        if (dut_low !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset drive actual=%0b expected=0", dut_low);
        end
        rst_n = 1'b1;
        tick(5);
        checks++;
        if (dut_low !== 1'b0) begin
            failures++;
            $display("FAIL R1 idle drive actual=%0b expected=0", dut_low);
        end

        // R2 R4: write 3 bytes from pointer 2 to the reset address 7'h38.
        bus_start();
        send_byte({7'h38, 1'b0}, 1'b1, "R1 R2 address ack");
        send_byte(8'h02, 1'b1, "R4 pointer ack");
        send_byte(8'hA1, 1'b1, "R4 data ack");
        send_byte(8'hB2, 1'b1, "R4 data ack");
        send_byte(8'hC3, 1'b1, "R4 data ack");
        bus_stop();

        // R7 R5 R6: set pointer, repeated START, read back, end on NACK.
        bus_start();
        send_byte({7'h38, 1'b0}, 1'b1, "R2 address ack");
        send_byte(8'h02, 1'b1, "R4 pointer ack");
        bus_start();
        send_byte({7'h38, 1'b1}, 1'b1, "R7 read address ack");
        recv_byte(8'hA1, 1'b1, "R5 read byte 2");
        recv_byte(8'hB2, 1'b1, "R5 read byte 3");
        recv_byte(8'hC3, 1'b0, "R5 read byte 4");
        bus_stop();

        // R6: pointer stayed on the NACKed byte.
        bus_start();
        send_byte({7'h38, 1'b1}, 1'b1, "R2 read address ack");
        recv_byte(8'hC3, 1'b0, "R6 pointer held after NACK");
        bus_stop();

        // R3: wrong address, data ignored; then recover with repeated START.
        bus_start();
        send_byte({7'h39, 1'b0}, 1'b0, "R3 address nack");
        send_byte(8'h05, 1'b0, "R3 ignored byte nack");
        send_byte(8'h77, 1'b0, "R3 ignored byte nack");
        bus_start();
        send_byte({7'h38, 1'b0}, 1'b1, "R3 recovery ack");
        send_byte(8'h05, 1'b1, "R4 pointer ack");
        bus_start();
        send_byte({7'h38, 1'b1}, 1'b1, "R7 read address ack");
        recv_byte(8'h00, 1'b0, "R3 register unchanged");
        bus_stop();

        // R9 R8: write across the top into the control register (nibble 6 -> 7'h36).
        bus_start();
        send_byte({7'h38, 1'b0}, 1'b1, "R2 address ack");
        send_byte(8'h0F, 1'b1, "R4 pointer ack");
        send_byte(8'h5A, 1'b1, "R9 data ack");
        send_byte(8'h6B, 1'b1, "R9 wrapped data ack");
        bus_stop();
        bus_start();
        send_byte({7'h38, 1'b0}, 1'b0, "R8 old address nack");
        bus_stop();
        bus_start();
        send_byte({7'h36, 1'b0}, 1'b1, "R8 new address ack");
        send_byte(8'h0F, 1'b1, "R4 pointer ack");
        bus_start();
        send_byte({7'h36, 1'b1}, 1'b1, "R8 read address ack");
        recv_byte(8'h5A, 1'b1, "R9 read top register");
        recv_byte(8'h6B, 1'b0, "R9 read wraps to control");
        bus_stop();

        // R7: repeated START inside write traffic re-opens with a pointer byte.
        bus_start();
        send_byte({7'h36, 1'b0}, 1'b1, "R2 address ack");
        send_byte(8'h08, 1'b1, "R4 pointer ack");
        send_byte(8'h11, 1'b1, "R4 data ack");
        bus_start();
        send_byte({7'h36, 1'b0}, 1'b1, "R7 address ack");
        send_byte(8'h09, 1'b1, "R7 pointer ack");
        send_byte(8'h22, 1'b1, "R7 data ack");
        bus_stop();
        bus_start();
        send_byte({7'h36, 1'b0}, 1'b1, "R2 address ack");
        send_byte(8'h08, 1'b1, "R4 pointer ack");
        bus_start();
        send_byte({7'h36, 1'b1}, 1'b1, "R7 read address ack");
        recv_byte(8'h11, 1'b1, "R7 byte before repeated START");
        recv_byte(8'h22, 1'b0, "R7 byte after repeated START");
        bus_stop();

        tick(10);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule